// File: doc/BRIEF.md
# Dependency-Aware Power Resource Sequencer

This block turns a set of power resources (regulators, power switches, oscillators, PLLs) on and off in an order that respects their dependencies. It runs from the slow sleep clock, and every clock edge counts as one tick. Each tick it gathers demand from three places: a programmable floor mask, core request lines passed through a programmable map, and a bank of one-shot request timers. It widens that demand to cover every resource the requested ones rely on, directly or indirectly. It then moves each resource through a timed four-state cycle.

Software sets up the floor mask, the dependency rows, the per-resource rise and fall times, the request map and the request timers through a single-cycle write port. The outputs report, for each resource, the enable line that drives the resource, the settled state bit and the in-transition (pending) bit.

Top module: `pmu_seq_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every resource returns to off, every countdown and request timer clears, and every configuration register reads zero. After reset, `res_state`, `res_pend` and `res_en` are all zero.
- R2: The demand set is the OR of three sources: the floor mask; the map row of every asserted `core_req` line; and the mask of every request timer whose count is nonzero.
- R3: The required set is closed under dependency. If a required resource has bit j set in its dependency row (bit j set means the resource depends on resource j), then resource j is also required, and this applies transitively. The diagonal bit of a row is ignored.
- R4: An off resource that is required and whose dependencies are all on starts rising on the next edge, with its countdown loaded from its rise time. It reaches on after exactly that many further edges. With a rise time of zero it goes straight from off to on in one edge.
- R5: An on resource that is not required and has no powered dependent starts falling, with its countdown loaded from its fall time. It reaches off after exactly that many further edges. With a fall time of zero it goes straight from on to off.
- R6: A resource does not leave off while any of its dependencies is in a state other than settled on.
- R7: A resource does not leave on while any resource that depends on it is in a state other than off.
- R8: A rising or falling resource completes its countdown whatever happens to demand. A change of demand is acted on only after the resource has settled.
- R9: A write to a request timer's load address sets its count. The count then falls by one per tick until it reaches zero, and the timer's mask is demanded while the count is nonzero.
- R10: Per resource, `res_state` is 1 when the resource is on or falling, `res_pend` is 1 when it is rising or falling, and `res_en` is 1 when it is rising or on.
- R11: Write address bits [7:4] select a page and bits [3:0] select an index. Page 0 index 0 is the floor mask. Page 1 holds dependency rows, page 2 rise times, page 3 fall times, page 4 request map rows, page 5 request timer masks and page 6 request timer loads. A write takes effect on the next tick, and writes to an unused index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sleep clock; every rising edge is one tick |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Write address: page in [7:4], index in [3:0] |
| cfg_wdata | input | 32 | Write data, low bits used per register |
| core_req | input | NREQ | Core request lines, each mapped to a resource mask |
| res_en | output | NRES | Enable line per resource (rising or on) |
| res_state | output | NRES | Settled state bit per resource (on or falling) |
| res_pend | output | NRES | Transition pending bit per resource |

## Verification
Two rules can act in the same tick: a dependent releasing its demand and its dependency deciding whether it may fall. The bench provokes this by dropping one core request that covers both a resource and the resource it relies on. It then checks that the dependency stays on until the exact tick the dependent reaches off, and starts falling only one tick later. A second collision comes from a request timer running out in the same tick that the floor mask or a request map changes. Long random write and request traffic over an acyclic dependency graph produces this collision. In both cases a behavioural model, stepped every tick, judges every output bit of every cycle, and directed checks confirm the hand-computed tick counts.

// File: rtl/pmu_seq_pkg.sv
// Package: shared types and address decode constants for the power
// resource sequencer. Assumes at most 16 resources, 16 request lines
// and 16 request timers (one 4-bit index field).
package pmu_seq_pkg;

    // Bit 1 is the settled state bit, bit 0 is the pending bit.
    typedef enum logic [1:0] {
        RS_OFF  = 2'b00,
        RS_RISE = 2'b01,
        RS_ON   = 2'b10,
        RS_FALL = 2'b11
    } res_st_e;

    localparam int CFG_AW = 8;
    localparam int CFG_DW = 32;

    localparam logic [3:0] PG_FLOOR = 4'h0;
    localparam logic [3:0] PG_DEP   = 4'h1;
    localparam logic [3:0] PG_RISE  = 4'h2;
    localparam logic [3:0] PG_FALL  = 4'h3;
    localparam logic [3:0] PG_MAP   = 4'h4;
    localparam logic [3:0] PG_TMASK = 4'h5;
    localparam logic [3:0] PG_TLOAD = 4'h6;

endpackage

// File: rtl/pmu_cfg_regs.sv
// Module: configuration register file. Decodes single-cycle writes into
// the floor mask, dependency rows, rise/fall times, request map rows and
// request timer masks, and produces one-cycle load strobes for the
// request timers. Assumes NRES, TW, RTW <= CFG_DW and counts <= 16.
module pmu_cfg_regs
    import pmu_seq_pkg::*;
#(
    parameter int NRES = 8,
    parameter int NREQ = 4,
    parameter int NRRT = 2,
    parameter int TW   = 8,
    parameter int RTW  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [CFG_AW-1:0]           addr,
    input  logic [CFG_DW-1:0]           wdata,
    output logic [NRES-1:0]             floor_mask,
    output logic [NRES-1:0][NRES-1:0]   dep_row,
    output logic [NRES-1:0][TW-1:0]     t_rise,
    output logic [NRES-1:0][TW-1:0]     t_fall,
    output logic [NREQ-1:0][NRES-1:0]   req_map,
    output logic [NRRT-1:0][NRES-1:0]   tmr_mask,
    output logic [NRRT-1:0]             tmr_load,
    output logic [RTW-1:0]              tmr_value
);

    logic [3:0] page;
    logic [3:0] idx;
    logic       wdata_unused;

    assign page         = addr[CFG_AW-1:4];
    assign idx          = addr[3:0];
    assign wdata_unused = ^wdata;
    assign tmr_value    = wdata[RTW-1:0];

    // Per-resource registers: dependency rows and rise/fall times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dep_row <= '0;
            t_rise  <= '0;
            t_fall  <= '0;
        end else if (we) begin
            for (int i = 0; i < NRES; i++) begin
                if (idx == 4'(i)) begin
                    if (page == PG_DEP)  dep_row[i] <= wdata[NRES-1:0];
                    if (page == PG_RISE) t_rise[i]  <= wdata[TW-1:0];
                    if (page == PG_FALL) t_fall[i]  <= wdata[TW-1:0];
                end
            end
        end
    end

    // Demand-source registers: floor mask, request map, timer masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            floor_mask <= '0;
            req_map    <= '0;
            tmr_mask   <= '0;
        end else if (we) begin
            if (page == PG_FLOOR && idx == 4'd0) floor_mask <= wdata[NRES-1:0];
            for (int k = 0; k < NREQ; k++) begin
                if (page == PG_MAP && idx == 4'(k)) req_map[k] <= wdata[NRES-1:0];
            end
            for (int t = 0; t < NRRT; t++) begin
                if (page == PG_TMASK && idx == 4'(t)) tmr_mask[t] <= wdata[NRES-1:0];
            end
        end
    end

    // Load strobe for each request timer.
    always_comb begin
        for (int t = 0; t < NRRT; t++) begin
            tmr_load[t] = we && (page == PG_TLOAD) && (idx == 4'(t));
        end
    end

endmodule

// File: rtl/pmu_req_timers.sv
// Module: bank of request timers. Each is a down-counter on the sleep
// clock that demands its resource mask while its count is nonzero.
// A load strobe overrides the decrement in the same tick.
module pmu_req_timers #(
    parameter int NRES = 8,
    parameter int NRRT = 2,
    parameter int RTW  = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRRT-1:0]           load,
    input  logic [RTW-1:0]            load_val,
    input  logic [NRRT-1:0][NRES-1:0] mask,
    output logic [NRES-1:0]           tmr_need
);

    logic [NRRT-1:0][RTW-1:0] cnt;

    for (genvar t = 0; t < NRRT; t++) begin : g_tmr
        // Count down to zero, or reload on a write.
        always_ff @(posedge clk) begin
            if (!rst_n)               cnt[t] <= '0;
            else if (load[t])         cnt[t] <= load_val;
            else if (cnt[t] != '0)    cnt[t] <= cnt[t] - 1'b1;
        end

        a_r9_timer_ticks: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(load[t]) && $past(cnt[t]) != '0) |-> (cnt[t] == $past(cnt[t]) - 1'b1));
        a_r9_timer_rests: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(load[t]) && $past(cnt[t]) == '0) |-> (cnt[t] == '0));
    end

    // OR together the masks of the timers that are still running.
    always_comb begin
        tmr_need = '0;
        for (int t = 0; t < NRRT; t++) begin
            if (cnt[t] != '0) tmr_need = tmr_need | mask[t];
        end
    end

endmodule

// File: rtl/pmu_need_closure.sv
// Module: dependency closure. Widens the demand set until every
// dependency of a demanded resource is itself demanded. Unrolled NRES
// times, which covers the longest possible chain. Expects the diagonal
// of the dependency rows to be cleared by the caller.
module pmu_need_closure #(
    parameter int NRES = 8
) (
    input  logic [NRES-1:0]           base,
    input  logic [NRES-1:0][NRES-1:0] dep,
    output logic [NRES-1:0]           need
);

    // Repeatedly fold in the dependency rows of the demanded resources.
    always_comb begin
        logic [NRES-1:0] acc;
        logic [NRES-1:0] nxt;
        acc = base;
        for (int it = 0; it < NRES; it++) begin
            nxt = acc;
            for (int i = 0; i < NRES; i++) begin
                if (acc[i]) nxt = nxt | dep[i];
            end
            acc = nxt;
        end
        need = acc;
    end

endmodule

// File: rtl/pmu_res_ctrl.sv
// Module: four-state controller for one resource. Starts a rise when the
// resource is required and its dependencies are settled on, and starts a
// fall when it is unrequired and no dependent is powered. A transition
// always runs its full count before demand is looked at again.
module pmu_res_ctrl
    import pmu_seq_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          need_i,
    input  logic          deps_on,
    input  logic          users_up,
    input  logic [TW-1:0] t_rise,
    input  logic [TW-1:0] t_fall,
    output res_st_e       st
);

    logic [TW-1:0] cnt;

    // Advance the resource state and its countdown by one tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RS_OFF;
            cnt <= '0;
        end else begin
            unique case (st)
                RS_OFF: if (need_i && deps_on) begin
                    if (t_rise == '0) st <= RS_ON;
                    else begin
                        st  <= RS_RISE;
                        cnt <= t_rise;
                    end
                end
                RS_RISE: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == TW'(1)) st <= RS_ON;
                end
                RS_ON: if (!need_i && !users_up) begin
                    if (t_fall == '0) st <= RS_OFF;
                    else begin
                        st  <= RS_FALL;
                        cnt <= t_fall;
                    end
                end
                RS_FALL: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == TW'(1)) st <= RS_OFF;
                end
                default: st <= RS_OFF;
            endcase
        end
    end

    a_r6_rise_after_deps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == RS_OFF && st != RS_OFF) |-> $past(need_i && deps_on));
    a_r7_fall_after_users: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == RS_ON && st != RS_ON) |-> $past(!need_i && !users_up));
    a_r8_rise_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == RS_RISE) |-> (st == RS_RISE || st == RS_ON));
    a_r8_fall_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == RS_FALL) |-> (st == RS_FALL || st == RS_OFF));
    a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st[0]) && st == $past(st)) |-> (cnt == $past(cnt) - 1'b1));
    a_r4_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        st[0] |-> (cnt != '0));
    a_r5_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !st[0] |-> (cnt == '0));

endmodule

// File: rtl/pmu_seq_top.sv
// Module: power resource sequencer top. Combines the three demand
// sources, closes the demand under dependency, derives per-resource
// dependency and dependent status from the controller states, and drives
// the enable, state and pending outputs. Assumes an acyclic dependency
// graph; the diagonal of each dependency row is ignored.
module pmu_seq_top
    import pmu_seq_pkg::*;
#(
    parameter int NRES = 8,
    parameter int NREQ = 4,
    parameter int NRRT = 2,
    parameter int TW   = 8,
    parameter int RTW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic [NREQ-1:0]   core_req,
    output logic [NRES-1:0]   res_en,
    output logic [NRES-1:0]   res_state,
    output logic [NRES-1:0]   res_pend
);

    localparam logic [NRES-1:0] ONE = NRES'(1);

    logic [NRES-1:0]             floor_mask;
    logic [NRES-1:0][NRES-1:0]   dep_row;
    logic [NRES-1:0][NRES-1:0]   dep_eff;
    logic [NRES-1:0][NRES-1:0]   user_col;
    logic [NRES-1:0][TW-1:0]     t_rise;
    logic [NRES-1:0][TW-1:0]     t_fall;
    logic [NREQ-1:0][NRES-1:0]   req_map;
    logic [NRRT-1:0][NRES-1:0]   tmr_mask;
    logic [NRRT-1:0]             tmr_load;
    logic [RTW-1:0]              tmr_value;
    logic [NRES-1:0]             tmr_need;
    logic [NRES-1:0]             base;
    logic [NRES-1:0]             need;
    logic [NRES-1:0]             on_vec;
    logic [NRES-1:0]             up_vec;
    logic [NRES-1:0]             deps_on;
    logic [NRES-1:0]             users_up;
    res_st_e                     st_arr [NRES];

    pmu_cfg_regs #(
        .NRES(NRES), .NREQ(NREQ), .NRRT(NRRT), .TW(TW), .RTW(RTW)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .floor_mask (floor_mask),
        .dep_row    (dep_row),
        .t_rise     (t_rise),
        .t_fall     (t_fall),
        .req_map    (req_map),
        .tmr_mask   (tmr_mask),
        .tmr_load   (tmr_load),
        .tmr_value  (tmr_value)
    );

    pmu_req_timers #(
        .NRES(NRES), .NRRT(NRRT), .RTW(RTW)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_value),
        .mask     (tmr_mask),
        .tmr_need (tmr_need)
    );

    // Union of floor mask, mapped core requests and running timers.
    always_comb begin
        base = floor_mask | tmr_need;
        for (int k = 0; k < NREQ; k++) begin
            if (core_req[k]) base = base | req_map[k];
        end
    end

    pmu_need_closure #(.NRES(NRES)) u_close (
        .base (base),
        .dep  (dep_eff),
        .need (need)
    );

    for (genvar i = 0; i < NRES; i++) begin : g_res
        assign dep_eff[i] = dep_row[i] & ~(ONE << i);

        for (genvar j = 0; j < NRES; j++) begin : g_col
            assign user_col[i][j] = dep_eff[j][i];
        end

        assign deps_on[i]  = ((dep_eff[i] & ~on_vec) == '0);
        assign users_up[i] = |(user_col[i] & up_vec);

        pmu_res_ctrl #(.TW(TW)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .need_i   (need[i]),
            .deps_on  (deps_on[i]),
            .users_up (users_up[i]),
            .t_rise   (t_rise[i]),
            .t_fall   (t_fall[i]),
            .st       (st_arr[i])
        );

        assign on_vec[i]    = (st_arr[i] == RS_ON);
        assign up_vec[i]    = (st_arr[i] != RS_OFF);
        assign res_state[i] = st_arr[i][1];
        assign res_pend[i]  = st_arr[i][0];
        assign res_en[i]    = (st_arr[i] == RS_RISE) || (st_arr[i] == RS_ON);

        a_r3_closed: assert property (@(posedge clk) disable iff (!rst_n)
            need[i] |-> ((dep_eff[i] & ~need) == '0));
        a_r2_base_covered: assert property (@(posedge clk) disable iff (!rst_n)
            base[i] |-> need[i]);
    end

endmodule

// File: tb/tb_pmu_seq_top.sv
`timescale 1ns/1ps
module tb_pmu_seq_top;

    localparam int NRES = 8;
    localparam int NREQ = 4;
    localparam int NRRT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [NREQ-1:0] core_req = '0;
    logic [NRES-1:0] res_en, res_state, res_pend;

    int vec = 0;
    int miss = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pmu_seq_top #(.NRES(NRES), .NREQ(NREQ), .NRRT(NRRT), .TW(8), .RTW(12)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .core_req(core_req),
        .res_en(res_en), .res_state(res_state), .res_pend(res_pend)
    );

    // Behavioural reference model: states 0 off, 1 rising, 2 on, 3 falling.
    int         mst [NRES];
    int         mcnt [NRES];
    int         nst [NRES];
    int         ncnt [NRES];
    int         mrise [NRES];
    int         mfall [NRES];
    int         mtc [NRRT];
    logic [7:0] mdep [NRES];
    logic [7:0] mmap [NREQ];
    logic [7:0] mtm [NRRT];
    logic [7:0] mfloor, mdem, mprev, mon;
    bit         busy_user, deps_ok;

    always @(posedge clk) begin
        if (!rst_n) begin
            mfloor = '0;
            foreach (mst[i]) begin
                mst[i] = 0; mcnt[i] = 0; mrise[i] = 0; mfall[i] = 0; mdep[i] = '0;
            end
            foreach (mmap[k]) mmap[k] = '0;
            foreach (mtc[t]) begin mtc[t] = 0; mtm[t] = '0; end
        end else begin
            mdem = mfloor;
            foreach (mmap[k]) if (core_req[k]) mdem |= mmap[k];
            foreach (mtc[t]) if (mtc[t] != 0) mdem |= mtm[t];
            do begin
                mprev = mdem;
                foreach (mst[i]) if (mdem[i]) mdem |= mdep[i] & ~(8'd1 << i);
            end while (mdem != mprev);
            mon = '0;
            foreach (mst[i]) if (mst[i] == 2) mon[i] = 1'b1;
            foreach (mst[i]) begin
                nst[i] = mst[i]; ncnt[i] = mcnt[i];
                deps_ok = ((mdep[i] & ~(8'd1 << i) & ~mon) == 0);
                busy_user = 0;
                foreach (mst[j]) if (j != i && mdep[j][i] && mst[j] != 0) busy_user = 1;
                case (mst[i])
                    0: if (mdem[i] && deps_ok) begin
                        if (mrise[i] == 0) nst[i] = 2;
                        else begin nst[i] = 1; ncnt[i] = mrise[i]; end
                    end
                    2: if (!mdem[i] && !busy_user) begin
                        if (mfall[i] == 0) nst[i] = 0;
                        else begin nst[i] = 3; ncnt[i] = mfall[i]; end
                    end
                    default: begin
                        ncnt[i] = mcnt[i] - 1;
                        if (ncnt[i] == 0) nst[i] = (mst[i] == 1) ? 2 : 0;
                    end
                endcase
            end
            foreach (mst[i]) begin mst[i] = nst[i]; mcnt[i] = ncnt[i]; end
            foreach (mtc[t]) begin
                if (cfg_we && cfg_addr[7:4] == 4'h6 && cfg_addr[3:0] == t) mtc[t] = int'(cfg_wdata[11:0]);
                else if (mtc[t] != 0) mtc[t]--;
            end
            if (cfg_we) begin
                int pg, ix;
                pg = int'(cfg_addr[7:4]); ix = int'(cfg_addr[3:0]);
                if (pg == 0 && ix == 0) mfloor = cfg_wdata[7:0];
                if (ix < NRES) begin
                    if (pg == 1) mdep[ix]  = cfg_wdata[7:0];
                    if (pg == 2) mrise[ix] = int'(cfg_wdata[7:0]);
                    if (pg == 3) mfall[ix] = int'(cfg_wdata[7:0]);
                end
                if (pg == 4 && ix < NREQ) mmap[ix] = cfg_wdata[7:0];
                if (pg == 5 && ix < NRRT) mtm[ix] = cfg_wdata[7:0];
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of every output against the model (R10 encoding).
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] es, ep, ee;
            es = '0; ep = '0; ee = '0;
            foreach (mst[i]) begin
                es[i] = (mst[i] >= 2);
                ep[i] = (mst[i] == 1 || mst[i] == 3);
                ee[i] = (mst[i] == 1 || mst[i] == 2);
            end
            chk("R10", "cycle res_state", res_state, es);
            chk("R10", "cycle res_pend", res_pend, ep);
            chk("R10", "cycle res_en", res_en, ee);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL R4 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1: everything off after reset
        chk("R1", "reset state", res_state, 8'h00);
        chk("R1", "reset pend", res_pend, 8'h00);
        chk("R1", "reset en", res_en, 8'h00);

        // R4/R11: resource 0 rise 3, fall 2, demanded by the floor mask
        wr(8'h20, 32'd3); wr(8'h30, 32'd2);
        wr(8'h00, 32'h01);
        wait_n(1);
        chk("R10", "rising en/pend", res_en & res_pend & 8'h01, 8'h01);
        wait_n(2);
        chk("R4", "still rising", res_pend & 8'h01, 8'h01);
        wait_n(1);
        chk("R4", "on after rise time", {res_state[0], res_pend[0]}, 8'h02);

        // R5: release, fall time 2
        wr(8'h00, 32'h00);
        wait_n(2);
        chk("R5", "falling", res_state & res_pend & 8'h01, 8'h01);
        wait_n(1);
        chk("R5", "off after fall time", res_state & 8'h01, 8'h00);

        // R4/R5 zero times on resource 2
        wr(8'h00, 32'h04);
        wait_n(1);
        chk("R4", "zero rise direct on", {res_state[2], res_pend[2]}, 8'h02);
        wr(8'h00, 32'h00);
        wait_n(1);
        chk("R5", "zero fall direct off", res_state & 8'h04, 8'h00);

        // R3/R6/R2: resource 3 depends on resource 1, requested via core line 0
        wr(8'h13, 32'h02); wr(8'h21, 32'd2); wr(8'h23, 32'd1);
        wr(8'h31, 32'd1); wr(8'h33, 32'd3); wr(8'h40, 32'h08);
        core_req = 4'b0001;
        wait_n(3);
        chk("R3", "dependency pulled in and on", res_state & 8'h0A, 8'h02);
        chk("R6", "dependent waits for dependency", res_pend & 8'h08, 8'h00);
        wait_n(2);
        chk("R2", "mapped core request served", res_state & 8'h0A, 8'h0A);

        // R7: release both; dependency holds until dependent is off
        core_req = 4'b0000;
        wait_n(4);
        chk("R7", "dependency held on", {res_state & 8'h0A, res_pend[1]}, 9'h004);
        wait_n(1);
        chk("R7", "dependency falls next tick", res_pend & 8'h02, 8'h02);
        wait_n(1);
        chk("R7", "both off", res_state & 8'h0A, 8'h00);

        // R8: release during a 5-tick rise of resource 4
        wr(8'h24, 32'd5);
        wr(8'h00, 32'h10);
        wait_n(1);
        wr(8'h00, 32'h00);
        wait_n(3);
        chk("R8", "rise not reversed", res_en & res_pend & 8'h10, 8'h10);
        wait_n(1);
        chk("R8", "rise completes to on", res_state & 8'h10, 8'h10);
        wait_n(1);
        chk("R5", "then falls with zero time", res_state & 8'h10, 8'h00);

        // R9: request timer 0 demands resource 5 for three ticks
        wr(8'h50, 32'h20);
        wr(8'h60, 32'd3);
        wait_n(1);
        chk("R9", "timer demand on", res_state & 8'h20, 8'h20);
        wait_n(3);
        chk("R9", "timer expired", res_state & 8'h20, 8'h00);

        // R3: diagonal bit ignored on resource 7
        wr(8'h17, 32'h80);
        wr(8'h00, 32'h80);
        wait_n(1);
        chk("R3", "self dependency ignored", res_state & 8'h80, 8'h80);
        wr(8'h0F, 32'hFF);
        wait_n(1);
        chk("R11", "unused floor index ignored", res_state & 8'h7F, 8'h00);
        wr(8'h00, 32'h00);

        // Random traffic over an acyclic graph, judged per cycle
        for (int n = 0; n < 3000; n++) begin
            int act, pg, ix;
            act = $urandom_range(0, 9);
            if (act < 5) begin
                pg = $urandom_range(0, 6);
                ix = $urandom_range(0, 8);
                case (pg)
                    1: wr({4'(pg), 4'(ix)}, ($urandom() & ((32'd1 << ix) - 1)));
                    2, 3: wr({4'(pg), 4'(ix)}, $urandom_range(0, 3));
                    6: wr({4'(pg), 4'(ix)}, $urandom_range(0, 12));
                    default: wr({4'(pg), 4'(ix)}, $urandom() & 32'hFF);
                endcase
            end else if (act < 7) begin
                core_req = 4'($urandom());
                wait_n(1);
            end else begin
                wait_n(1);
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

endmodule